// File: doc/BRIEF.md
# Linear Support Vector Machine Classification Core

The core classifies one query vector with a two-class linear support vector machine that was trained elsewhere. Before a run, the host streams the support-vector features into an on-chip store, together with one signed coefficient per support vector. Each coefficient is the Lagrange multiplier already multiplied by that vector's +1/-1 training class. The host then streams the query features into a small buffer.

A one-cycle start pulse captures a pair of class codes. The core then walks every support vector, one feature multiply-accumulate per clock, to form its dot product with the query. It scales each finished dot product by the vector's coefficient and adds the result to a signed running total. The sign of the final total selects one of the two class codes, and a completion flag pulses for one cycle.

The port set is a superset of the ports of an interchangeable nearest-neighbour core. The coefficient input is the only port specific to this classifier.

Top module: `svm_classifier`

## Requirements
- R1: While reset is asserted, and after its release until the first result, `result_done` is 0 and `result_class` is 0.
- R2: The decision value is the sum over every support vector s of coef[s] × Σ_f feat[s][f] × query[f]. All words are signed two's complement of `WORD_W` bits.
- R3: A decision value of zero or more yields the positive code and a negative value yields the negative code. An exact zero counts as positive.
- R4: `class_codes` is sampled on the cycle a start is accepted. Bits [LBL_W-1:0] are the positive code and bits [2*LBL_W-1:LBL_W] are the negative code. Later changes have no effect on that run.
- R5: Each `ld_sv` beat writes `sv_word` at the next position in vector-major order (feature index fastest). `coef_word` is stored only on beats where the feature index is 0. The write position wraps to vector 0, feature 0 after the last feature of the last vector.
- R6: Each `ld_query` beat writes `query_word` at the next feature index. The index wraps to 0 after feature `NUM_FEAT-1`.
- R7: `result_done` is high for exactly one cycle. It rises NUM_SV×NUM_FEAT+2 clock edges after the edge that accepts `run_en`.
- R8: `result_class` holds its value at all times except the cycle on which `result_done` rises.
- R9: While a run is in progress, `run_en`, `ld_sv` and `ld_query` are ignored. Stored vectors, coefficients and query words are left intact, and the completion time does not move.
- R10: The total cannot overflow, even when every feature, query word and coefficient is at its most negative or most positive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Start a classification (accepted when idle) |
| ld_sv | input | 1 | Write one support-vector feature word |
| ld_query | input | 1 | Write one query feature word |
| sv_word | input | WORD_W | Support-vector feature word |
| class_codes | input | 2*LBL_W | {negative code, positive code} |
| coef_word | input | WORD_W | Signed coefficient, taken on feature-0 beats |
| query_word | input | WORD_W | Query feature word |
| result_done | output | 1 | One-cycle completion pulse |
| result_class | output | LBL_W | Selected class code |

## Verification
The hardest situation to reach is a decision value of exactly zero. The sign rule only shows there, and random data almost never produces it. The stimulus reaches it by loading two identical support vectors with opposite coefficients and zero coefficients everywhere else. Two other cases also need deliberate stimulus. Loads, starts and code changes are injected in the middle of a run, and a second run without reloading then shows that the stored data was not touched. Every word is also driven to its extreme value to push the total toward the limits of its width.

// File: rtl/svm_pkg.sv
package svm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_DRAIN = 2'd2
  } phase_t;

  // Index width for a counter over n positions (at least 1 bit).
  function automatic int idx_w(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // Width of one dot product: a product plus growth for nf terms plus margin.
  function automatic int dot_width(input int w, input int nf);
    return 2 * w + idx_w(nf) + 1;
  endfunction

  // Width of the running total over ns scaled dot products.
  function automatic int total_width(input int w, input int ns, input int nf);
    return dot_width(w, nf) + w + idx_w(ns) + 1;
  endfunction

endpackage

// File: rtl/svm_sv_store.sv
module svm_sv_store
  import svm_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int NUM_SV   = 64,
  parameter int NUM_FEAT = 20
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic signed [WORD_W-1:0]         wr_feat,
  input  logic signed [WORD_W-1:0]         wr_coef,
  input  logic [idx_w(NUM_SV*NUM_FEAT)-1:0] rd_addr,
  input  logic [idx_w(NUM_SV)-1:0]         rd_vec,
  output logic signed [WORD_W-1:0]         rd_feat,
  output logic signed [WORD_W-1:0]         rd_coef
);

  localparam int DEPTH = NUM_SV * NUM_FEAT;
  localparam int AW    = idx_w(DEPTH);
  localparam int SW    = idx_w(NUM_SV);
  localparam int FW    = idx_w(NUM_FEAT);

  logic signed [WORD_W-1:0] feat_mem [DEPTH];
  logic signed [WORD_W-1:0] coef_mem [NUM_SV];

  logic [AW-1:0] wr_addr;
  logic [SW-1:0] wr_vec;
  logic [FW-1:0] wr_ft;

  wire at_end_w  = (int'(wr_addr) == DEPTH - 1);
  wire ft_last_w = (int'(wr_ft) == NUM_FEAT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      wr_vec  <= '0;
      wr_ft   <= '0;
    end else if (wr_en) begin
      if (at_end_w) begin
        wr_addr <= '0;
        wr_vec  <= '0;
        wr_ft   <= '0;
      end else begin
        wr_addr <= wr_addr + AW'(1);
        if (ft_last_w) begin
          wr_ft  <= '0;
          wr_vec <= wr_vec + SW'(1);
        end else begin
          wr_ft <= wr_ft + FW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      feat_mem[wr_addr] <= wr_feat;
      if (wr_ft == '0) coef_mem[wr_vec] <= wr_coef;
    end
  end

  assign rd_feat = feat_mem[rd_addr];
  assign rd_coef = coef_mem[rd_vec];

  p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_addr) < DEPTH);
  p_ft_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ft_last_w) |=> (wr_ft == '0));
  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_addr));

endmodule

// File: rtl/svm_query_buf.sv
module svm_query_buf
  import svm_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int NUM_FEAT = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic signed [WORD_W-1:0]   wr_word,
  input  logic [idx_w(NUM_FEAT)-1:0] rd_idx,
  output logic signed [WORD_W-1:0]   rd_word
);

  localparam int FW = idx_w(NUM_FEAT);

  logic signed [WORD_W-1:0] q_mem [NUM_FEAT];
  logic [FW-1:0] wr_idx;

  wire wr_last_w = (int'(wr_idx) == NUM_FEAT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wr_idx <= '0;
    else if (wr_en) wr_idx <= wr_last_w ? '0 : wr_idx + FW'(1);
  end

  always_ff @(posedge clk) begin
    if (wr_en) q_mem[wr_idx] <= wr_word;
  end

  assign rd_word = q_mem[rd_idx];

  p_qptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_idx) < NUM_FEAT);
  p_qptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_idx));

endmodule

// File: rtl/svm_dot_engine.sv
module svm_dot_engine
  import svm_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int NUM_SV   = 64,
  parameter int NUM_FEAT = 20
) (
  input  logic                                                clk,
  input  logic                                                rst_n,
  input  logic                                                clear,
  input  logic                                                mac_en,
  input  logic                                                last_feat,
  input  logic                                                last_all,
  input  logic signed [WORD_W-1:0]                            feat,
  input  logic signed [WORD_W-1:0]                            qword,
  input  logic signed [WORD_W-1:0]                            coef,
  output logic signed [total_width(WORD_W,NUM_SV,NUM_FEAT)-1:0] total,
  output logic                                                sum_done
);

  localparam int PROD_W = 2 * WORD_W;
  localparam int DOT_W  = dot_width(WORD_W, NUM_FEAT);
  localparam int TERM_W = DOT_W + WORD_W;
  localparam int TOT_W  = total_width(WORD_W, NUM_SV, NUM_FEAT);

  // One feature step of the dot product.
  function automatic logic signed [DOT_W-1:0] mac_step(
    input logic signed [DOT_W-1:0]  acc,
    input logic signed [WORD_W-1:0] a,
    input logic signed [WORD_W-1:0] b);
    logic signed [PROD_W-1:0] p;
    p = PROD_W'(a) * PROD_W'(b);
    return acc + DOT_W'(p);
  endfunction

  // Coefficient times finished dot product.
  function automatic logic signed [TERM_W-1:0] scale_term(
    input logic signed [WORD_W-1:0] c,
    input logic signed [DOT_W-1:0]  d);
    return TERM_W'(c) * TERM_W'(d);
  endfunction

  logic signed [DOT_W-1:0]  dot_acc, dot_hold;
  logic signed [WORD_W-1:0] coef_hold;
  logic                     scale_vld, scale_fin;
  logic signed [TOT_W-1:0]  total_r;

  wire signed [DOT_W-1:0]  dot_next_w = mac_step(dot_acc, feat, qword);
  wire signed [TERM_W-1:0] term_w     = scale_term(coef_hold, dot_hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_acc   <= '0;
      dot_hold  <= '0;
      coef_hold <= '0;
      scale_vld <= 1'b0;
      scale_fin <= 1'b0;
      total_r   <= '0;
      sum_done  <= 1'b0;
    end else begin
      scale_vld <= 1'b0;
      scale_fin <= 1'b0;
      sum_done  <= 1'b0;
      if (clear) begin
        dot_acc <= '0;
        total_r <= '0;
      end else begin
        if (mac_en) begin
          if (last_feat) begin
            dot_hold  <= dot_next_w;
            coef_hold <= coef;
            scale_vld <= 1'b1;
            scale_fin <= last_all;
            dot_acc   <= '0;
          end else begin
            dot_acc <= dot_next_w;
          end
        end
        if (scale_vld) begin
          total_r  <= total_r + TOT_W'(term_w);
          sum_done <= scale_fin;
        end
      end
    end
  end

  assign total = total_r;

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_vld && !clear && (total_r[TOT_W-1] == term_w[TERM_W-1]))
      |=> (total_r[TOT_W-1] == $past(total_r[TOT_W-1])));
  p_sum_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sum_done |=> !sum_done);

endmodule

// File: rtl/svm_classifier.sv
module svm_classifier
  import svm_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int NUM_SV   = 64,
  parameter int NUM_FEAT = 20,
  parameter int LBL_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic                 ld_sv,
  input  logic                 ld_query,
  input  logic [WORD_W-1:0]    sv_word,
  input  logic [2*LBL_W-1:0]   class_codes,
  input  logic [WORD_W-1:0]    coef_word,
  input  logic [WORD_W-1:0]    query_word,
  output logic                 result_done,
  output logic [LBL_W-1:0]     result_class
);

  localparam int DEPTH = NUM_SV * NUM_FEAT;
  localparam int AW    = idx_w(DEPTH);
  localparam int SW    = idx_w(NUM_SV);
  localparam int FW    = idx_w(NUM_FEAT);
  localparam int TOT_W = total_width(WORD_W, NUM_SV, NUM_FEAT);

  function automatic logic total_nonneg(input logic signed [TOT_W-1:0] t);
    return !t[TOT_W-1];
  endfunction

  phase_t                    phase;
  logic [AW-1:0]             rd_addr;
  logic [SW-1:0]             s_idx;
  logic [FW-1:0]             f_idx;
  logic [LBL_W-1:0]          pos_code, neg_code;
  logic signed [WORD_W-1:0]  feat_rd, coef_rd, q_rd;
  logic signed [TOT_W-1:0]   total;
  logic                      sum_done;

  wire idle_w      = (phase == PH_IDLE);
  wire accept_w    = run_en && idle_w;
  wire sv_wr_ok_w  = ld_sv && idle_w;
  wire q_wr_ok_w   = ld_query && idle_w;
  wire mac_en_w    = (phase == PH_RUN);
  wire last_feat_w = (int'(f_idx) == NUM_FEAT - 1);
  wire last_all_w  = last_feat_w && (int'(s_idx) == NUM_SV - 1);

  svm_sv_store #(.WORD_W(WORD_W), .NUM_SV(NUM_SV), .NUM_FEAT(NUM_FEAT)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sv_wr_ok_w),
    .wr_feat (sv_word),
    .wr_coef (coef_word),
    .rd_addr (rd_addr),
    .rd_vec  (s_idx),
    .rd_feat (feat_rd),
    .rd_coef (coef_rd)
  );

  svm_query_buf #(.WORD_W(WORD_W), .NUM_FEAT(NUM_FEAT)) u_query (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (q_wr_ok_w),
    .wr_word (query_word),
    .rd_idx  (f_idx),
    .rd_word (q_rd)
  );

  svm_dot_engine #(.WORD_W(WORD_W), .NUM_SV(NUM_SV), .NUM_FEAT(NUM_FEAT)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept_w),
    .mac_en    (mac_en_w),
    .last_feat (last_feat_w),
    .last_all  (last_all_w),
    .feat      (feat_rd),
    .qword     (q_rd),
    .coef      (coef_rd),
    .total     (total),
    .sum_done  (sum_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      rd_addr      <= '0;
      s_idx        <= '0;
      f_idx        <= '0;
      pos_code     <= '0;
      neg_code     <= '0;
      result_done  <= 1'b0;
      result_class <= '0;
    end else begin
      result_done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (accept_w) begin
            phase    <= PH_RUN;
            rd_addr  <= '0;
            s_idx    <= '0;
            f_idx    <= '0;
            pos_code <= class_codes[LBL_W-1:0];
            neg_code <= class_codes[2*LBL_W-1:LBL_W];
          end
        end
        PH_RUN: begin
          if (last_all_w) begin
            phase <= PH_DRAIN;
          end else begin
            rd_addr <= rd_addr + AW'(1);
            if (last_feat_w) begin
              f_idx <= '0;
              s_idx <= s_idx + SW'(1);
            end else begin
              f_idx <= f_idx + FW'(1);
            end
          end
        end
        PH_DRAIN: begin
          if (sum_done) begin
            result_class <= total_nonneg(total) ? pos_code : neg_code;
            result_done  <= 1'b1;
            phase        <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_done |=> !result_done);
  p_done_from_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_done |-> $past(sum_done));
  p_class_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !result_done |-> $stable(result_class));
  p_class_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result_done |-> (result_class == pos_code || result_class == neg_code));
  p_run_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && !last_all_w) |=>
      (phase == PH_RUN && rd_addr == $past(rd_addr) + AW'(1)));

endmodule

// File: tb/svm_classifier_test.sv
module svm_classifier_test;

  localparam int CLK_P = 10;
  localparam int TS    = 6;
  localparam int TF    = 4;
  localparam int TW    = 8;
  localparam int TL    = 4;
  localparam int LAT   = TS * TF + 2;

  typedef struct {
    logic [TL-1:0] cls;
    int            cyc;
    string         req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, ld_sv = 1'b0, ld_query = 1'b0;
  logic [TW-1:0]   sv_word = '0, coef_word = '0, query_word = '0;
  logic [2*TL-1:0] class_codes = '0;
  logic            result_done;
  logic [TL-1:0]   result_class;

  int checks = 0, failures = 0, cyc = 0;
  int sv [TS][TF];
  int cf [TS];
  int qv [TF];
  exp_t exp_q [$];

  svm_classifier #(.WORD_W(TW), .NUM_SV(TS), .NUM_FEAT(TF), .LBL_W(TL)) uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ld_sv(ld_sv), .ld_query(ld_query),
    .sv_word(sv_word), .class_codes(class_codes), .coef_word(coef_word),
    .query_word(query_word), .result_done(result_done), .result_class(result_class));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Scoreboard monitor: compares every completion against the queue head.
  always @(negedge clk) begin
    if (rst_n && result_done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(result_class == e.cls, e.req, longint'(result_class), longint'(e.cls));
        check(cyc == e.cyc, "R7 completion cycle", cyc, e.cyc);
      end
    end
  end

  function automatic longint model_total();
    longint acc = 0;
    for (int i = 0; i < TS; i++) begin
      longint d = 0;
      for (int j = 0; j < TF; j++) d += longint'(sv[i][j]) * longint'(qv[j]);
      acc += longint'(cf[i]) * d;
    end
    return acc;
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < TS; i++) begin
      cf[i] = ((i * 29 + seed * 7) % 256) - 128;
      for (int j = 0; j < TF; j++) sv[i][j] = ((i * 37 + j * 11 + seed * 5) % 256) - 128;
    end
    for (int j = 0; j < TF; j++) qv[j] = ((j * 53 + seed * 3) % 256) - 128;
  endtask

  // R5: coefficient is presented correctly only on feature-0 beats; junk otherwise.
  task automatic load_svs();
    for (int i = 0; i < TS; i++)
      for (int j = 0; j < TF; j++) begin
        @(negedge clk);
        ld_sv = 1'b1;
        sv_word = TW'(sv[i][j]);
        coef_word = (j == 0) ? TW'(cf[i]) : 8'h7F;
      end
    @(negedge clk) ld_sv = 1'b0;
  endtask

  task automatic load_query();
    for (int j = 0; j < TF; j++) begin
      @(negedge clk);
      ld_query = 1'b1;
      query_word = TW'(qv[j]);
    end
    @(negedge clk) ld_query = 1'b0;
  endtask

  task automatic start(input logic [TL-1:0] pc, input logic [TL-1:0] nc, input string req);
    exp_t e;
    longint t;
    @(negedge clk);
    run_en = 1'b1;
    class_codes = {nc, pc};
    t = model_total();
    e.cls = (t >= 0) ? pc : nc;
    e.cyc = cyc + 1 + LAT;
    e.req = req;
    exp_q.push_back(e);
    @(negedge clk) run_en = 1'b0;
  endtask

  // Wait for the scoreboard to drain, then check R8 hold.
  task automatic finish_run();
    logic [TL-1:0] held;
    while (exp_q.size() != 0) @(negedge clk);
    held = result_class;
    repeat (4) @(negedge clk);
    check(result_class == held, "R8 class held after completion", result_class, held);
    check(result_done == 1'b0, "R7 completion is a single pulse", result_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(result_done == 1'b0, "R1 done at reset", result_done, 0);
    check(result_class == '0, "R1 class at reset", result_class, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(result_done == 1'b0 && result_class == '0, "R1 idle after release", result_class, 0);

    // R2: general pattern
    fill(1); load_svs(); load_query();
    start(4'h5, 4'hA, "R2 decision pattern 1"); finish_run();

    // R3: negated coefficients flip the sign
    for (int i = 0; i < TS; i++) cf[i] = -cf[i];
    load_svs();
    start(4'h5, 4'hA, "R3 negated coefficients"); finish_run();

    // R2: another pattern
    fill(9); load_svs(); load_query();
    start(4'h3, 4'hC, "R2 decision pattern 2"); finish_run();

    // R3: exact zero total counts as positive
    for (int i = 0; i < TS; i++) cf[i] = 0;
    for (int j = 0; j < TF; j++) sv[1][j] = sv[0][j];
    cf[0] = 5; cf[1] = -5;
    load_svs();
    check(model_total() == 0, "R3 zero total constructed", model_total(), 0);
    start(4'h6, 4'h9, "R3 zero total gives positive code"); finish_run();

    // R10: extremes
    for (int i = 0; i < TS; i++) begin
      cf[i] = 127;
      for (int j = 0; j < TF; j++) sv[i][j] = -128;
    end
    for (int j = 0; j < TF; j++) qv[j] = -128;
    load_svs(); load_query();
    start(4'h1, 4'hE, "R10 extreme positive"); finish_run();
    for (int i = 0; i < TS; i++) cf[i] = -128;
    load_svs();
    start(4'h1, 4'hE, "R10 extreme negative"); finish_run();
    for (int j = 0; j < TF; j++) qv[j] = 127;
    load_query();
    start(4'h1, 4'hE, "R10 extreme mixed sign"); finish_run();

    // R9 / R4: activity during a run is ignored; codes captured at start
    fill(4); load_svs(); load_query();
    start(4'h2, 4'hD, "R9 R4 busy inputs ignored");
    repeat (3) @(negedge clk);
    class_codes = 8'hFF;
    ld_sv = 1'b1; sv_word = 8'h7F; coef_word = 8'h7F; ld_query = 1'b1; query_word = 8'h80;
    run_en = 1'b1;
    repeat (3) @(negedge clk);
    ld_sv = 1'b0; ld_query = 1'b0; run_en = 1'b0;
    finish_run();
    start(4'h2, 4'hD, "R9 stored data intact after busy writes"); finish_run();

    // R5 / R6: a fresh full load overwrites the previous one from position 0
    fill(7); load_svs(); load_query();
    for (int j = 0; j < TF; j++) qv[j] = -qv[j];
    load_query();
    start(4'h4, 4'hB, "R5 R6 reload wraps and overwrites"); finish_run();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule